// File: doc/BRIEF.md
# Width-Matching Dual-Clock FIFO

This block moves words between two unrelated clock domains. The write side and the read side each have their own clock, and the two may run at any rates, including stopped. Each port is either 18 or 9 bits wide, and this is chosen by its own strap. When an 18-bit producer feeds a 9-bit consumer, every stored word leaves as two halves. When a 9-bit producer feeds an 18-bit consumer, two writes are packed into one word.

A third strap picks how the read side behaves. In standard timing the output register changes only when a read is requested, and the two status pins act as full and empty. In fall-through timing the head word moves onto the output by itself. The status pins then act as write-ready and data-valid, and a read request retires the word on display. All three straps are captured while master reset is held low. A separate partial reset empties the queue but keeps the captured configuration.

Top module: `wm_fifo`

## Requirements
- R1: `inWide` and `outWide` (1 = 18 bits, 0 = 9 bits) and `fwftSel` are captured only while `mrstN` is low. A 9-bit input uses `din[8:0]`. A 9-bit output appears on `dout[8:0]` with `dout[17:9]` zero. Changing the straps after `mrstN` rises has no effect.
- R2: A word is accepted at a rising `wrClk` edge when `wrEnN` is low and the FIFO is not full. No other edge stores data.
- R3: With an 18-bit input and a 9-bit output, each stored word is read as `din[17:9]` first and `din[8:0]` second.
- R4: With a 9-bit input and an 18-bit output, the first write fills `dout[17:9]` and the second fills `dout[8:0]`. A word with only one half written is not readable.
- R5: In standard timing (`fwftSel`=0), `dout` resets to zero. It changes only at a rising `rdClk` edge with `rdEnN` low while data is available, and it then loads the head word.
- R6: In standard timing, `wrFlagN` is low exactly when DEPTH words are stored, and `rdFlagN` is low when nothing is readable. Both go low right after the edge that causes the condition.
- R7: In fall-through timing (`fwftSel`=1), a word written into an empty FIFO appears on `dout` at the third rising `rdClk` edge after its write edge, with no read request. A read request retires it and brings the next word.
- R8: In fall-through timing, `wrFlagN` is low while space remains and `rdFlagN` is low while a valid word is on `dout`. With no read request, that word and `rdFlagN` stay put.
- R9: A write while full and a read while empty are ignored. Stored data, order and the output are unchanged.
- R10: Words leave in the order they were written, without loss or duplication, across unrelated clock rates.
- R11: Holding `prstN` low empties the FIFO and clears both domains' state (`rdFlagN` low and `wrFlagN` high in standard timing). The width and timing configuration captured at the last master reset is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| mrstN | input | 1 | Master reset, active low; straps are captured while low |
| prstN | input | 1 | Partial reset, active low; keeps configuration |
| inWide | input | 1 | Strap: 1 = 18-bit input, 0 = 9-bit input |
| outWide | input | 1 | Strap: 1 = 18-bit output, 0 = 9-bit output |
| fwftSel | input | 1 | Strap: 1 = fall-through timing, 0 = standard timing |
| wrEnN | input | 1 | Write request, active low |
| din | input | 18 | Write data |
| rdEnN | input | 1 | Read request, active low |
| dout | output | 18 | Registered read data |
| wrFlagN | output | 1 | Full (standard) or write-ready (fall-through), active low |
| rdFlagN | output | 1 | Empty (standard) or data-valid (fall-through), active low |

## Verification
The assertions check on every clock several properties:
- the fill level never exceeds DEPTH;
- the read pointer never moves while the FIFO is empty;
- both Gray pointers change by at most one bit per edge;
- a first half-write never commits a word;
- the output register holds whenever no load is strobed;
- in fall-through timing, a displayed word stays while no read is requested.

Some behaviour can only be shown by the bench's scenarios against its queue model:
- the half ordering when widths differ;
- the exact three-edge fall-through delay;
- that the straps are ignored after reset;
- that partial reset keeps the configuration;
- that a rejected write never shows up in the output stream.

// File: rtl/wm_fifo_pkg.sv
package wm_fifo_pkg;

  // write-side strobes from control to datapath
  typedef struct packed {
    logic wrHi;      // store into upper-half bank
    logic wrLo;      // store into lower-half bank
    logic narrowIn;  // upper bank takes din low half (9-bit input)
  } wrStb_t;

  // read-side strobes from control to datapath
  typedef struct packed {
    logic load;      // load output register from head
    logic takeLo;    // narrow output picks lower bank
    logic wideOut;   // output both halves
  } rdStb_t;

endpackage

// File: rtl/wm_fifo_sync.sv
module wm_fifo_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/wm_fifo_ctrl.sv
module wm_fifo_ctrl
  import wm_fifo_pkg::*;
#(
  parameter  int DEPTH       = 8,
  parameter  int SYNC_STAGES = 2,
  localparam int AW          = $clog2(DEPTH),
  localparam int PW          = AW + 1
) (
  // write domain
  input  logic          wrClk,
  input  logic          wrRstN,
  input  logic          mrstN,
  input  logic          inWide,
  input  logic          outWide,
  input  logic          fwftSel,
  input  logic          wrEnN,
  output wrStb_t        wrStb,
  output logic [AW-1:0] wrAddr,
  output logic          wrFlagN,
  // read domain
  input  logic          rdClk,
  input  logic          rdRstN,
  input  logic          rdEnN,
  output rdStb_t        rdStb,
  output logic [AW-1:0] rdAddr,
  output logic          rdFlagN,
  output logic          fwftMode
);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic          wrIn18, wrOut18, wrFwft;
  logic [PW-1:0] wrBin, wrGray, wrBinNext, rdGraySync, rdSyncBin;
  logic          wrHalf, full, wrOk, wrJoin, wrCommit;

  // straps sampled on clock edges while master reset is held
  always_ff @(posedge wrClk) begin
    if (!mrstN) {wrIn18, wrOut18, wrFwft} <= {inWide, outWide, fwftSel};
  end

  wm_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rdPtrSync (
    .clk(wrClk), .rstN(wrRstN), .d(rdGrayQ), .q(rdGraySync)
  );

  assign rdSyncBin = fromGray(rdGraySync);
  assign wrJoin    = !wrIn18 && wrOut18;
  assign full      = (wrBin[AW] != rdSyncBin[AW]) &&
                     (wrBin[AW-1:0] == rdSyncBin[AW-1:0]);
  assign wrOk      = !wrEnN && !full && wrRstN;
  assign wrCommit  = wrOk && (!wrJoin || wrHalf);
  assign wrBinNext = wrBin + PW'(wrCommit);

  always_comb begin
    wrStb = '0;
    if (wrIn18) begin
      wrStb.wrHi = wrOk;
      wrStb.wrLo = wrOk;
    end else if (wrJoin) begin
      wrStb.wrHi     = wrOk && !wrHalf;
      wrStb.wrLo     = wrOk && wrHalf;
      wrStb.narrowIn = 1'b1;
    end else begin
      wrStb.wrHi     = wrOk;
      wrStb.narrowIn = 1'b1;
    end
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin  <= '0;
      wrGray <= '0;
      wrHalf <= 1'b0;
    end else begin
      wrBin  <= wrBinNext;
      wrGray <= toGray(wrBinNext);
      if (wrOk && wrJoin) wrHalf <= !wrHalf;
    end
  end

  assign wrAddr  = wrBin[AW-1:0];
  assign wrFlagN = wrFwft ? full : !full;

  // ---------------- read domain ----------------
  logic          rdIn18, rdOut18, rdFwft;
  logic [PW-1:0] rdBin, rdGrayQ, rdBinNext, wrGraySync, wrSyncBin;
  logic          rdHalf, memEmpty, take, rdSplit, rdCommit, outValid;

  always_ff @(posedge rdClk) begin
    if (!mrstN) {rdIn18, rdOut18, rdFwft} <= {inWide, outWide, fwftSel};
  end

  wm_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wrPtrSync (
    .clk(rdClk), .rstN(rdRstN), .d(wrGray), .q(wrGraySync)
  );

  assign wrSyncBin = fromGray(wrGraySync);
  assign rdSplit   = rdIn18 && !rdOut18;
  assign memEmpty  = (rdBin == wrSyncBin);
  assign take      = rdRstN && !memEmpty &&
                     (rdFwft ? (!outValid || !rdEnN) : !rdEnN);
  assign rdCommit  = take && (!rdSplit || rdHalf);
  assign rdBinNext = rdBin + PW'(rdCommit);

  always_comb begin
    rdStb         = '0;
    rdStb.load    = take;
    rdStb.takeLo  = rdSplit && rdHalf;
    rdStb.wideOut = rdOut18;
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin    <= '0;
      rdGrayQ  <= '0;
      rdHalf   <= 1'b0;
      outValid <= 1'b0;
    end else begin
      rdBin   <= rdBinNext;
      rdGrayQ <= toGray(rdBinNext);
      if (take && rdSplit) rdHalf <= !rdHalf;
      if (take)            outValid <= 1'b1;
      else if (!rdEnN)     outValid <= 1'b0;
    end
  end

  assign rdAddr   = rdBin[AW-1:0];
  assign rdFlagN  = rdFwft ? !outValid : !memEmpty;
  assign fwftMode = rdFwft;

  // ---------------- assertions ----------------
  p_fill_bound_r6: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrBin - rdSyncBin) <= PW'(DEPTH));

  p_no_underflow_r9: assert property (@(posedge rdClk) disable iff (!rdRstN)
    memEmpty |=> $stable(rdBin));

  p_wr_gray_step_r10: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  p_rd_gray_step_r10: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $countones(rdGrayQ ^ $past(rdGrayQ)) <= 1);

  p_half_no_commit_r4: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrJoin && !wrHalf) |=> $stable(wrBin));

endmodule

// File: rtl/wm_fifo_dp.sv
module wm_fifo_dp
  import wm_fifo_pkg::*;
#(
  parameter  int DEPTH  = 8,
  parameter  int HALF_W = 9,
  localparam int AW     = $clog2(DEPTH),
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              wrClk,
  input  wrStb_t            wrStb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [FULL_W-1:0] din,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  rdStb_t            rdStb,
  input  logic [AW-1:0]     rdAddr,
  output logic [FULL_W-1:0] dout
);

  logic [HALF_W-1:0] memHi [DEPTH];
  logic [HALF_W-1:0] memLo [DEPTH];
  logic [FULL_W-1:0] headWord;

  always_ff @(posedge wrClk) begin
    if (wrStb.wrHi)
      memHi[wrAddr] <= wrStb.narrowIn ? din[HALF_W-1:0] : din[FULL_W-1:HALF_W];
    if (wrStb.wrLo)
      memLo[wrAddr] <= din[HALF_W-1:0];
  end

  always_comb begin
    if (rdStb.wideOut)
      headWord = {memHi[rdAddr], memLo[rdAddr]};
    else
      headWord = {{HALF_W{1'b0}}, (rdStb.takeLo ? memLo[rdAddr] : memHi[rdAddr])};
  end

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN)         dout <= '0;
    else if (rdStb.load) dout <= headWord;
  end

  p_out_hold_r5: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !rdStb.load |=> $stable(dout));

endmodule

// File: rtl/wm_fifo.sv
module wm_fifo
  import wm_fifo_pkg::*;
#(
  parameter  int DEPTH       = 8,
  parameter  int HALF_W      = 9,
  parameter  int SYNC_STAGES = 2,
  localparam int AW          = $clog2(DEPTH),
  localparam int FULL_W      = 2 * HALF_W
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrstN,
  input  logic              prstN,
  input  logic              inWide,
  input  logic              outWide,
  input  logic              fwftSel,
  input  logic              wrEnN,
  input  logic [FULL_W-1:0] din,
  input  logic              rdEnN,
  output logic [FULL_W-1:0] dout,
  output logic              wrFlagN,
  output logic              rdFlagN
);

  logic          rstN;
  wrStb_t        wrStb;
  rdStb_t        rdStb;
  logic [AW-1:0] wrAddr, rdAddr;
  logic          fwftMode;

  assign rstN = mrstN & prstN;

  wm_fifo_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk(wrClk), .wrRstN(rstN), .mrstN(mrstN),
    .inWide(inWide), .outWide(outWide), .fwftSel(fwftSel),
    .wrEnN(wrEnN), .wrStb(wrStb), .wrAddr(wrAddr), .wrFlagN(wrFlagN),
    .rdClk(rdClk), .rdRstN(rstN), .rdEnN(rdEnN), .rdStb(rdStb),
    .rdAddr(rdAddr), .rdFlagN(rdFlagN), .fwftMode(fwftMode)
  );

  wm_fifo_dp #(.DEPTH(DEPTH), .HALF_W(HALF_W)) u_dp (
    .wrClk(wrClk), .wrStb(wrStb), .wrAddr(wrAddr), .din(din),
    .rdClk(rdClk), .rdRstN(rstN), .rdStb(rdStb), .rdAddr(rdAddr),
    .dout(dout)
  );

  p_fwft_hold_r8: assert property (@(posedge rdClk) disable iff (!rstN)
    (fwftMode && !rdFlagN && rdEnN) |=> (!rdFlagN && $stable(dout)));

endmodule

// File: tb/wm_fifo_test.sv
module wm_fifo_test;
  localparam int DEPTH = 8;
  localparam int HW    = 9;
  localparam int FW    = 18;

  logic wrClk = 0, rdClk = 0;
  always #2 wrClk = ~wrClk;   // 250 MHz write clock
  always #5 rdClk = ~rdClk;   // unrelated read clock

  logic mrstN = 0, prstN = 1, inWide = 1, outWide = 1, fwftSel = 0;
  logic wrEnN = 1, rdEnN = 1;
  logic [FW-1:0] din = '0;
  logic [FW-1:0] dout;
  logic wrFlagN, rdFlagN;

  wm_fifo #(.DEPTH(DEPTH), .HALF_W(HW)) uut (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .prstN(prstN),
    .inWide(inWide), .outWide(outWide), .fwftSel(fwftSel),
    .wrEnN(wrEnN), .din(din), .rdEnN(rdEnN), .dout(dout),
    .wrFlagN(wrFlagN), .rdFlagN(rdFlagN)
  );

  int nTests = 0, nFail = 0;
  int rdEdges = 0;
  logic [FW-1:0] expQ [$];
  logic cfgIn18, cfgOut18, cfgFwft;
  logic [HW-1:0] pendHi;
  logic pendHalf;

  always @(posedge rdClk) rdEdges++;

  task automatic check(input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic masterReset(input bit in18, input bit out18, input bit fwft);
    mrstN = 0; wrEnN = 1; rdEnN = 1;
    inWide = in18; outWide = out18; fwftSel = fwft;
    repeat (3) @(negedge rdClk);
    #1 mrstN = 1;
    cfgIn18 = in18; cfgOut18 = out18; cfgFwft = fwft;
    expQ.delete(); pendHalf = 0;
    repeat (2) @(negedge rdClk);
  endtask

  // expected output items, built from the requirements (R3, R4, R1)
  task automatic model(input logic [FW-1:0] d);
    if (cfgIn18 && cfgOut18) expQ.push_back(d);
    else if (cfgIn18) begin
      expQ.push_back({{HW{1'b0}}, d[FW-1:HW]});
      expQ.push_back({{HW{1'b0}}, d[HW-1:0]});
    end else if (cfgOut18) begin
      if (!pendHalf) begin pendHi = d[HW-1:0]; pendHalf = 1; end
      else begin expQ.push_back({pendHi, d[HW-1:0]}); pendHalf = 0; end
    end else expQ.push_back({{HW{1'b0}}, d[HW-1:0]});
  endtask

  // driver
  task automatic pushWrite(input logic [FW-1:0] d, input bit accept);
    @(negedge wrClk); din = d; wrEnN = 0;
    @(negedge wrClk); wrEnN = 1;
    if (accept) model(d);
  endtask

  // monitor: pop one expected item and compare with the port
  task automatic popCheck(input string req);
    logic [FW-1:0] e;
    e = (expQ.size() > 0) ? expQ.pop_front() : 'x;
    @(negedge rdClk);
    if (!cfgFwft) begin
      while (rdFlagN !== 1'b1) @(negedge rdClk);
      rdEnN = 0;
      @(negedge rdClk); rdEnN = 1;
      check(req, dout, e);
    end else begin
      while (rdFlagN !== 1'b0) @(negedge rdClk);
      check(req, dout, e);
      rdEnN = 0;
      @(negedge rdClk); rdEnN = 1;
    end
  endtask

  initial begin
    #400000;
    nTests++; nFail++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int mark, lat;
    logic [FW-1:0] held;

    // ---- standard timing, 18 in / 18 out ----
    masterReset(1, 1, 0);
    check("R6 reset full flag", {17'b0, wrFlagN}, 18'd1);
    check("R6 reset empty flag", {17'b0, rdFlagN}, 18'd0);
    check("R5 reset output", dout, 18'h0);

    @(negedge rdClk); rdEnN = 0;
    @(negedge rdClk); rdEnN = 1;
    check("R9 read while empty keeps output", dout, 18'h0);
    check("R9 read while empty keeps empty", {17'b0, rdFlagN}, 18'd0);

    pushWrite(18'h1_2345, 1);
    pushWrite(18'h2_ABCD, 1);
    pushWrite(18'h3_0F0F, 1);
    repeat (4) @(negedge rdClk);
    check("R5 no read leaves output", dout, 18'h0);
    popCheck("R2 first word");
    popCheck("R10 order 2");
    popCheck("R10 order 3");

    // ---- fill to DEPTH, overflow attempt ----
    for (int i = 0; i < DEPTH; i++) pushWrite(FW'(18'h1000 + i * 7), 1);
    check("R6 full after DEPTH writes", {17'b0, wrFlagN}, 18'd0);
    pushWrite(18'h3_FFFF, 0);
    for (int i = 0; i < DEPTH; i++) popCheck("R10 full drain");
    check("R9 overflow write dropped", {17'b0, rdFlagN}, 18'd0);
    repeat (4) @(negedge wrClk);
    check("R6 not full after drain", {17'b0, wrFlagN}, 18'd1);

    // ---- 18 in / 9 out, straps moved after reset ----
    masterReset(1, 0, 0);
    inWide = 0; outWide = 1; fwftSel = 1;
    pushWrite(18'h2_A5C3, 1);
    pushWrite(18'h1_5E77, 1);
    popCheck("R3 upper half first");
    popCheck("R3 lower half second");
    popCheck("R1 straps ignored after reset");
    popCheck("R3 second word lower");

    // ---- 9 in / 18 out ----
    masterReset(0, 1, 0);
    pushWrite(18'h3_E1AB, 1);
    repeat (6) @(negedge rdClk);
    check("R4 half word not readable", {17'b0, rdFlagN}, 18'd0);
    pushWrite(18'h0_0155, 1);
    popCheck("R4 joined word");
    pushWrite(18'h0_0001, 1); pushWrite(18'h0_01FE, 1);
    pushWrite(18'h0_0123, 1); pushWrite(18'h0_0042, 1);
    popCheck("R4 joined 2");
    popCheck("R10 joined 3");

    // ---- 9 in / 9 out ----
    masterReset(0, 0, 0);
    pushWrite(18'h3_FE11, 1);
    pushWrite(18'h0_00A2, 1);
    popCheck("R1 narrow output zero upper");
    popCheck("R1 narrow second");

    // ---- fall-through timing ----
    masterReset(1, 1, 1);
    check("R8 reset write-ready", {17'b0, wrFlagN}, 18'd0);
    check("R8 reset no valid", {17'b0, rdFlagN}, 18'd1);
    @(negedge wrClk); din = 18'h2_4681; wrEnN = 0;
    @(posedge wrClk); mark = rdEdges;
    @(negedge wrClk); wrEnN = 1;
    model(18'h2_4681);
    lat = 0;
    while (rdFlagN !== 1'b0 && lat < 20) begin
      @(posedge rdClk); #1;
      lat = rdEdges - mark;
    end
    check("R7 three read edges", FW'(lat), 18'd3);
    check("R7 word on output without read", dout, 18'h2_4681);
    popCheck("R7 retire first");
    check("R8 valid clears when drained", {17'b0, rdFlagN}, 18'd1);

    pushWrite(18'h0_1111, 1);
    pushWrite(18'h0_2222, 1);
    @(negedge rdClk);
    while (rdFlagN !== 1'b0) @(negedge rdClk);
    held = dout;
    repeat (5) @(negedge rdClk);
    check("R8 word held without read", dout, held);
    check("R8 valid held", {17'b0, rdFlagN}, 18'd0);
    popCheck("R7 fall-through order 1");
    popCheck("R7 fall-through order 2");
    for (int i = 0; i < 4; i++) pushWrite(FW'(18'h2_0000 + i * 3), 1);
    for (int i = 0; i < 4; i++) popCheck("R10 fall-through burst");

    // ---- partial reset keeps configuration ----
    masterReset(1, 0, 0);
    pushWrite(18'h1_0203, 1);
    pushWrite(18'h1_0405, 1);
    repeat (3) @(negedge rdClk);
    inWide = 0; outWide = 1; fwftSel = 1;
    prstN = 0;
    repeat (3) @(negedge rdClk);
    #1 prstN = 1;
    expQ.delete(); pendHalf = 0;
    repeat (2) @(negedge rdClk);
    check("R11 empty after partial reset", {17'b0, rdFlagN}, 18'd0);
    check("R11 not full after partial reset", {17'b0, wrFlagN}, 18'd1);
    pushWrite(18'h3_5A5A, 1);
    popCheck("R11 split kept upper");
    popCheck("R11 split kept lower");
    check("R11 old words discarded", {17'b0, rdFlagN}, 18'd0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule